// File: doc/BRIEF.md
# Four-Master Four-Slave Crossbar Switch

This block connects four bus masters to four bus slaves. Transfers to different slaves run at the same time. Each master drives an address, write data, a write flag and a priority. The top two address bits choose the target slave. Every slave port has its own arbiter. When a port is free, its arbiter picks one of the masters that address it. The larger priority value wins. Masters with equal priority are served in rotation, starting after the master that last held that port. The winner keeps the port until the slave signals completion. Only the owner of the port receives the read data and the done pulse from that slave.

On the master side, `m_req` acts as valid and `m_ready` as the completion handshake. A master raises `m_req` and holds its address, data and write flag stable until it sees `m_ready` high at a rising edge. It then either drops `m_req` or presents a new transfer. A master that loses arbitration simply waits: its `m_ready` stays low, which is the back-pressure. On the slave side, `s_req` marks a transfer in progress. The slave ends the transfer by raising `s_ready` for one cycle, and may stall by holding it low.

Top module: `xbar_quad_switch`

## Requirements
- R1: Slave index = master address bits [31:30]. When an idle port is requested with no contention, it presents that master's address on the port from the first rising edge at which the request is sampled.
- R2: An owned slave port shows the owner's address, write data and write flag, with `s_req` high. A port without an owner drives `s_req` low and zero on its address, data and write outputs.
- R3: Among requesters of one idle port, the master with the largest 2-bit `m_prio` value (bits [2m+1:2m]) is granted.
- R4: Ties at the top priority go to the first requester in the order last+1, last+2, … modulo 4, where "last" is the ID of the master most recently granted that port. After reset, last is 3, so master 0 wins the first tie.
- R5: Once granted, a port keeps its owner until the slave raises `s_ready`. Requests from other masters, even at higher priority, do not change the owner.
- R6: `m_ready[m]` equals `s_ready` of the slave port owned by master m, and `m_rdata` carries that port's read data. A master owning no port sees `m_ready` low and `m_rdata` zero.
- R7: A completed transfer frees its port at that edge. The port spends one cycle without an owner, and arbitration takes place in that cycle.
- R8: All four slave ports can be owned at the same time by different masters. No master owns more than one port.
- R9: During reset, and right after it, every `s_req` and every `m_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| m_req | input | 4 | Transfer request (valid), one bit per master |
| m_addr | input | 128 | Master addresses, 32 bits per master, master m at [32m+31:32m] |
| m_wdata | input | 128 | Master write data, 32 bits per master |
| m_we | input | 4 | Write flag per master |
| m_prio | input | 8 | 2-bit priority per master, larger wins |
| m_ready | output | 4 | Transfer done per master (returned ready) |
| m_rdata | output | 128 | Read data returned per master |
| s_req | output | 4 | Transfer in progress per slave port |
| s_addr | output | 128 | Address forwarded to each slave |
| s_wdata | output | 128 | Write data forwarded to each slave |
| s_we | output | 4 | Write flag forwarded to each slave |
| s_ready | input | 4 | Slave completion, one bit per slave |
| s_rdata | input | 128 | Read data from each slave |

## Verification
A request sampled at a rising edge on an idle port shows up on that port's outputs right after the same edge: one register stage. `m_ready` and `m_rdata` follow `s_ready` and `s_rdata` combinationally, within the same cycle. A completion at an edge leaves the port free for exactly the next cycle. The bench drives inputs on the falling edge and compares every port output 1 ns later against a cycle model updated once per clock. Completions therefore line up with the edge at which `s_ready` is sampled high. Directed runs log the order of grants on one watched port and compare it with the sequence that the priority and rotation rules predict.

// File: rtl/xbq_pkg.sv
package xbq_pkg;
  typedef enum logic {
    PORT_IDLE  = 1'b0,
    PORT_OWNED = 1'b1
  } port_state_e;
endpackage

// File: rtl/xbq_decode.sv
// Address decode: each master's top address bits select one slave.
module xbq_decode #(
  parameter int N_MST = 4,
  parameter int N_SLV = 4,
  parameter int AW    = 32
) (
  input  logic [N_MST-1:0]       m_req,
  input  logic [N_MST*AW-1:0]    m_addr,
  output logic [N_SLV*N_MST-1:0] slv_req
);
  localparam int SB = $clog2(N_SLV);

  for (genvar s = 0; s < N_SLV; s++) begin : g_slv
    for (genvar m = 0; m < N_MST; m++) begin : g_mst
      assign slv_req[s*N_MST + m] =
        m_req[m] && (m_addr[m*AW + AW - 1 -: SB] == SB'(s));
    end
  end
endmodule

// File: rtl/xbq_arbiter.sv
// One slave port arbiter. The owner register doubles as round-robin pointer.
module xbq_arbiter
  import xbq_pkg::*;
#(
  parameter int N_MST = 4,
  parameter int PW    = 2,
  localparam int IW   = $clog2(N_MST)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_MST-1:0]   req,
  input  logic [N_MST*PW-1:0] prio,
  input  logic               done,
  output logic               owned,
  output logic [IW-1:0]      owner
);
  port_state_e   state_q, state_d;
  logic [IW-1:0] owner_q, owner_d, win;
  logic          found;
  logic [PW-1:0] prio_a [N_MST];

  for (genvar k = 0; k < N_MST; k++) begin : g_prio
    assign prio_a[k] = prio[k*PW +: PW];
  end

  // Scan in rotation order from last owner + 1; strict compare keeps the
  // earliest master in that order among the highest priority.
  always_comb begin
    int            idx;
    logic [PW-1:0] best;
    win   = owner_q;
    found = 1'b0;
    best  = '0;
    idx   = 0;
    for (int k = 1; k <= N_MST; k++) begin
      idx = (int'(owner_q) + k) % N_MST;
      if (req[idx] && (!found || prio_a[idx] > best)) begin
        found = 1'b1;
        best  = prio_a[idx];
        win   = IW'(idx);
      end
    end
  end

  always_comb begin
    state_d = state_q;
    owner_d = owner_q;
    case (state_q)
      PORT_IDLE:  if (found) begin
                    state_d = PORT_OWNED;
                    owner_d = win;
                  end
      PORT_OWNED: if (done) state_d = PORT_IDLE;
      default:    state_d = PORT_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PORT_IDLE;
      owner_q <= IW'(N_MST - 1);
    end else begin
      state_q <= state_d;
      owner_q <= owner_d;
    end
  end

  assign owned = (state_q == PORT_OWNED);
  assign owner = owner_q;

  // R5: owner fixed until the slave completes
  assert_hold_owner_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (owned && !done) |=> (owned && $stable(owner_q)));

  // R7: completion frees the port for the next cycle
  assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (owned && done) |=> !owned);

  // R7: a free port with requesters is granted at the next edge
  assert_grant_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!owned && (|req)) |=> owned);

  // R3: the chosen master carries no lower priority than any requester
  for (genvar k = 0; k < N_MST; k++) begin : g_chk
    assert_winner_prio_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!owned && req[k]) |-> (found && prio_a[win] >= prio_a[k]));
  end
endmodule

// File: rtl/xbq_return.sv
// Return path: each master receives ready and read data only from the port it owns.
module xbq_return #(
  parameter int N_MST = 4,
  parameter int N_SLV = 4,
  parameter int DW    = 32,
  localparam int IW   = $clog2(N_MST)
) (
  input  logic [N_SLV-1:0]    owned,
  input  logic [N_SLV*IW-1:0] owner,
  input  logic [N_SLV-1:0]    s_ready,
  input  logic [N_SLV*DW-1:0] s_rdata,
  output logic [N_MST-1:0]    m_ready,
  output logic [N_MST*DW-1:0] m_rdata
);
  for (genvar m = 0; m < N_MST; m++) begin : g_mst
    always_comb begin
      m_ready[m]          = 1'b0;
      m_rdata[m*DW +: DW] = '0;
      for (int s = 0; s < N_SLV; s++) begin
        if (owned[s] && owner[s*IW +: IW] == IW'(m)) begin
          m_ready[m]          = s_ready[s];
          m_rdata[m*DW +: DW] = s_rdata[s*DW +: DW];
        end
      end
    end
  end
endmodule

// File: rtl/xbar_quad_switch.sv
module xbar_quad_switch #(
  parameter int N_MST = 4,
  parameter int N_SLV = 4,
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int PW    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_MST-1:0]    m_req,
  input  logic [N_MST*AW-1:0] m_addr,
  input  logic [N_MST*DW-1:0] m_wdata,
  input  logic [N_MST-1:0]    m_we,
  input  logic [N_MST*PW-1:0] m_prio,
  output logic [N_MST-1:0]    m_ready,
  output logic [N_MST*DW-1:0] m_rdata,
  output logic [N_SLV-1:0]    s_req,
  output logic [N_SLV*AW-1:0] s_addr,
  output logic [N_SLV*DW-1:0] s_wdata,
  output logic [N_SLV-1:0]    s_we,
  input  logic [N_SLV-1:0]    s_ready,
  input  logic [N_SLV*DW-1:0] s_rdata
);
  localparam int IW = $clog2(N_MST);

  logic [N_SLV*N_MST-1:0] slv_req;
  logic [N_SLV-1:0]       owned;
  logic [N_SLV*IW-1:0]    owner_flat;

  xbq_decode #(.N_MST(N_MST), .N_SLV(N_SLV), .AW(AW)) u_decode (
    .m_req   (m_req),
    .m_addr  (m_addr),
    .slv_req (slv_req)
  );

  for (genvar s = 0; s < N_SLV; s++) begin : g_slv
    logic [IW-1:0] own;

    xbq_arbiter #(.N_MST(N_MST), .PW(PW)) u_arb (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (slv_req[s*N_MST +: N_MST]),
      .prio  (m_prio),
      .done  (s_ready[s]),
      .owned (owned[s]),
      .owner (own)
    );

    assign owner_flat[s*IW +: IW] = own;
    assign s_req[s]               = owned[s];
    assign s_addr[s*AW +: AW]     = owned[s] ? m_addr[own*AW +: AW]  : '0;
    assign s_wdata[s*DW +: DW]    = owned[s] ? m_wdata[own*DW +: DW] : '0;
    assign s_we[s]                = owned[s] ? m_we[own] : 1'b0;
  end

  xbq_return #(.N_MST(N_MST), .N_SLV(N_SLV), .DW(DW)) u_return (
    .owned   (owned),
    .owner   (owner_flat),
    .s_ready (s_ready),
    .s_rdata (s_rdata),
    .m_ready (m_ready),
    .m_rdata (m_rdata)
  );

  // R8: ownership across the independent port arbiters never overlaps
  for (genvar m = 0; m < N_MST; m++) begin : g_excl
    logic [N_SLV-1:0] holds;
    for (genvar s = 0; s < N_SLV; s++) begin : g_bit
      assign holds[s] = owned[s] && (owner_flat[s*IW +: IW] == IW'(m));
    end
    assert_one_port_per_master_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(holds));
  end
endmodule

// File: tb/xbar_quad_switch_test.sv
module xbar_quad_switch_test;
  localparam int NM = 4, NS = 4, AW = 32, DW = 32, PW = 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic               rst_n;
  logic [NM-1:0]      m_req;
  logic [NM*AW-1:0]   m_addr;
  logic [NM*DW-1:0]   m_wdata;
  logic [NM-1:0]      m_we;
  logic [NM*PW-1:0]   m_prio;
  logic [NM-1:0]      m_ready;
  logic [NM*DW-1:0]   m_rdata;
  logic [NS-1:0]      s_req;
  logic [NS*AW-1:0]   s_addr;
  logic [NS*DW-1:0]   s_wdata;
  logic [NS-1:0]      s_we;
  logic [NS-1:0]      s_ready;
  logic [NS*DW-1:0]   s_rdata;

  xbar_quad_switch uut (
    .clk(clk), .rst_n(rst_n), .m_req(m_req), .m_addr(m_addr), .m_wdata(m_wdata),
    .m_we(m_we), .m_prio(m_prio), .m_ready(m_ready), .m_rdata(m_rdata),
    .s_req(s_req), .s_addr(s_addr), .s_wdata(s_wdata), .s_we(s_we),
    .s_ready(s_ready), .s_rdata(s_rdata)
  );

  int tests = 0, fails = 0, cyc = 0;

  // master stimulus state
  logic          act [NM];
  logic [AW-1:0] ma  [NM];
  logic [DW-1:0] md  [NM];
  logic          mw  [NM];
  logic [PW-1:0] mp  [NM];
  logic          done_m [NM];
  // expected port state (owner also serves as last-granted pointer)
  logic eb [NS];
  int   eo [NS];
  logic          force_rdy, auto_issue;
  logic [NS-1:0] rdy_val;
  int   watch_s;
  int   wlog[$];

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] actual, input logic [63:0] expected);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, actual, expected);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      fails++; tests++;
      $display("FAIL R7 watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  function automatic int pick(input int s);
    int best = -1;
    for (int k = 1; k <= NM; k++) begin
      int i = (eo[s] + k) % NM;
      if (act[i] && int'(ma[i][31:30]) == s && (best < 0 || mp[i] > mp[best]))
        best = i;
    end
    return best;
  endfunction

  task automatic issue(input int m, input int s, input int pr);
    act[m] = 1'b1;
    ma[m]  = {2'(s), 26'($urandom), 2'(m), 2'b00};
    md[m]  = $urandom;
    mw[m]  = 1'($urandom);
    mp[m]  = 2'(pr);
  endtask

  task automatic drive();
    for (int m = 0; m < NM; m++) begin
      m_req[m]            = act[m];
      m_addr[m*AW +: AW]  = ma[m];
      m_wdata[m*DW +: DW] = md[m];
      m_we[m]             = mw[m];
      m_prio[m*PW +: PW]  = mp[m];
    end
    s_ready = force_rdy ? rdy_val : NS'($urandom);
    for (int s = 0; s < NS; s++) s_rdata[s*DW +: DW] = $urandom;
  endtask

  task automatic step();
    @(negedge clk);
    for (int m = 0; m < NM; m++)
      if (done_m[m]) begin act[m] = 1'b0; done_m[m] = 1'b0; end
    if (auto_issue)
      for (int m = 0; m < NM; m++) begin
        if ($urandom % 4 == 0) mp[m] = 2'($urandom);
        if (!act[m] && ($urandom % 3 == 0)) issue(m, int'($urandom % 4), int'($urandom % 4));
      end
    drive();
    #1;
    for (int s = 0; s < NS; s++) begin
      chk(s_req[s] == eb[s], "R7", $sformatf("s_req[%0d]", s), 64'(s_req[s]), 64'(eb[s]));
      if (eb[s]) begin
        chk(s_addr[s*AW +: AW] == ma[eo[s]], "R1", $sformatf("s_addr[%0d]", s),
            64'(s_addr[s*AW +: AW]), 64'(ma[eo[s]]));
        chk(s_wdata[s*DW +: DW] == md[eo[s]], "R2", $sformatf("s_wdata[%0d]", s),
            64'(s_wdata[s*DW +: DW]), 64'(md[eo[s]]));
        chk(s_we[s] == mw[eo[s]], "R2", $sformatf("s_we[%0d]", s), 64'(s_we[s]), 64'(mw[eo[s]]));
        if (s_ready[s] && s == watch_s) wlog.push_back(int'(s_addr[s*AW + 2 +: 2]));
      end else begin
        chk(s_addr[s*AW +: AW] == '0 && s_wdata[s*DW +: DW] == '0 && !s_we[s], "R2",
            $sformatf("idle port %0d outputs", s), 64'(s_addr[s*AW +: AW]), 64'd0);
      end
    end
    for (int m = 0; m < NM; m++) begin
      logic          er = 1'b0;
      logic [DW-1:0] ed = '0;
      for (int s = 0; s < NS; s++)
        if (eb[s] && eo[s] == m) begin er = s_ready[s]; ed = s_rdata[s*DW +: DW]; end
      chk(m_ready[m] == er, "R6", $sformatf("m_ready[%0d]", m), 64'(m_ready[m]), 64'(er));
      chk(m_rdata[m*DW +: DW] == ed, "R6", $sformatf("m_rdata[%0d]", m),
          64'(m_rdata[m*DW +: DW]), 64'(ed));
      done_m[m] = er;
    end
    for (int s = 0; s < NS; s++) begin
      if (eb[s]) begin
        if (s_ready[s]) eb[s] = 1'b0;
      end else begin
        int b = pick(s);
        if (b >= 0) begin eb[s] = 1'b1; eo[s] = b; end
      end
    end
  endtask

  task automatic check_log(input string rq, input int n, input int e0, input int e1,
                           input int e2, input int e3);
    int exp_q[4] = '{e0, e1, e2, e3};
    chk(wlog.size() == n, rq, "grant count", 64'(wlog.size()), 64'(n));
    for (int i = 0; i < n && i < wlog.size(); i++)
      chk(wlog[i] == exp_q[i], rq, $sformatf("grant #%0d", i), 64'(wlog[i]), 64'(exp_q[i]));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    force_rdy = 1'b1; rdy_val = '0; auto_issue = 1'b0; watch_s = -1;
    for (int m = 0; m < NM; m++) begin
      act[m] = 0; ma[m] = '0; md[m] = '0; mw[m] = 0; mp[m] = '0; done_m[m] = 0;
    end
    for (int s = 0; s < NS; s++) begin eb[s] = 0; eo[s] = NM - 1; end
    // R9: requests present during reset must not leak through
    issue(0, 0, 1); issue(1, 1, 1);
    drive();
    repeat (3) @(posedge clk);
    #1;
    chk(s_req == '0, "R9", "s_req in reset", 64'(s_req), 64'd0);
    chk(m_ready == '0, "R9", "m_ready in reset", 64'(m_ready), 64'd0);
    act[0] = 0; act[1] = 0;
    @(negedge clk);
    drive();
    rst_n = 1'b1;
    #1;
    chk(s_req == '0 && m_ready == '0, "R9", "outputs after reset",
        64'({s_req, m_ready}), 64'd0);

    // R4: four-way tie on port 2, fresh pointer => 0,1,2,3
    rdy_val = '1; watch_s = 2; wlog.delete();
    for (int m = 0; m < NM; m++) issue(m, 2, 1);
    repeat (10) step();
    check_log("R4", 4, 0, 1, 2, 3);

    // R3: priorities 2,1,0,3 on port 1 => 3,0,1,2
    watch_s = 1; wlog.delete();
    issue(0, 1, 2); issue(1, 1, 1); issue(2, 1, 0); issue(3, 1, 3);
    repeat (10) step();
    check_log("R3", 4, 3, 0, 1, 2);

    // R5: low-priority owner keeps port 3 while a higher one waits
    watch_s = 3; wlog.delete(); rdy_val = '0;
    issue(0, 3, 0);
    repeat (2) step();
    issue(2, 3, 3);
    repeat (4) step();
    chk(s_addr[3*AW + 2 +: 2] == 2'd0, "R5", "owner held", 64'(s_addr[3*AW + 2 +: 2]), 64'd0);
    chk(m_ready[2] == 1'b0, "R6", "stalled master ready", 64'(m_ready[2]), 64'd0);
    rdy_val = '1;
    repeat (5) step();
    check_log("R5", 2, 0, 2, 0, 0);

    // R8: four masters on four different ports at once
    rdy_val = '0; watch_s = -1;
    issue(0, 1, 0); issue(1, 0, 0); issue(2, 3, 0); issue(3, 2, 0);
    repeat (2) step();
    chk(s_req == 4'hF, "R8", "all ports owned", 64'(s_req), 64'hF);
    rdy_val = '1;
    repeat (3) step();

    // random mixed traffic
    force_rdy = 1'b0; auto_issue = 1'b1;
    repeat (4000) step();
    auto_issue = 1'b0; force_rdy = 1'b1; rdy_val = '1;
    repeat (20) step();
    chk(s_req == '0, "R7", "drained", 64'(s_req), 64'd0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule